// File: doc/BRIEF.md
# Scratchpad Copy Commit and Memory Read Controller

This block is the byte-level back end of a serial-bus EEPROM's memory-function layer, for two commands: copy scratchpad (code 55h) and read memory (code F0h). A bit-slot front end passes it whole bytes. It gets one strobe for the command code and one for each byte the master writes. When the master opens a read slot group, the front end sends a request, and the block answers one cycle later with a byte.

For a copy, the master echoes three bytes. The block compares them with the current low address byte, high address byte and ending-offset/status byte, in that order. It then checks row alignment, address range, the partial-write flag and the copy-lock byte. If every gate passes, it pulses the flag-set output that marks the scratchpad as committed. It then writes the eight scratchpad bytes to the target row through a simple memory write port and holds `busy` for a fixed number of clock cycles. From then until a bus reset it answers every read request with an alternating bit pattern. If any gate fails, the block does nothing and answers all-ones until the next bus reset.

For a read, the master supplies a two-byte start address. The block then streams memory bytes in address order from a synchronous read port. It touches nothing else.

Top module: `cac_commit`

## Requirements
- R1: After a copy command, the three bytes that follow must equal `ta1`, `ta2` and `es`, in that order. Any mismatch means no write, no `aa_set` and no `busy`. Every later `tx_byte` is FFh until `bus_reset`.
- R2: A copy is only allowed if the target address {`ta2`,`ta1`} has its three low bits at zero and is at most 0080h. The rows at 0000h–0078h are data rows and 0080h is the register row. Any other target is blocked.
- R3: A copy is blocked when bit 5 of `es` (the partial-write flag) is 1.
- R4: If `copy_prot` is 55h or AAh, a copy is blocked when it targets the register row or a data page whose protection byte is 55h. Page p covers addresses p*32 to p*32+31, and its byte is `page_prot[8p+7:8p]`. A page byte of 55h with any other `copy_prot` value does not block, and neither does a page byte of AAh.
- R5: When a copy starts, `aa_set` is high for exactly one cycle. It rises in the same cycle as `busy`, and at no other time.
- R6: An allowed copy makes exactly eight writes, all while `busy` is high. Write i has address base+i and data `spad[8i+7:8i]`, in ascending order.
- R7: `busy` stays high for exactly PROG_CYCLES consecutive cycles for each allowed copy.
- R8: Once programming ends, every read request returns AAh, which is 0,1,0,1… least significant bit first. This holds until `bus_reset`, after which requests return FFh.
- R9: A blocked copy causes no `mem_we`, no `aa_set` and no `busy`.
- R10: After a read command and a low-then-high address byte, each read request returns the byte at the next sequential address, starting at the given address. Addresses above 008Fh return FFh. `tx_valid` follows `tx_req` by one cycle.
- R11: A read command never raises `mem_we` or `aa_set`.
- R12: A `bus_reset` during programming does not shorten `busy` or cancel any write. After programming the block returns to idle: requests get FFh, and a new command is accepted.
- R13: After `rst`, `busy`, `aa_set`, `mem_we` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle strobe: master sent a bus reset |
| cmd_valid | input | 1 | Memory-function command byte strobe |
| cmd_code | input | 8 | Command byte |
| rx_valid | input | 1 | Data byte from master strobe |
| rx_byte | input | 8 | Data byte from master |
| tx_req | input | 1 | Master opens a byte of read slots |
| tx_valid | output | 1 | Response byte valid, one cycle after `tx_req` |
| tx_byte | output | 8 | Response byte |
| ta1 | input | 8 | Target address, low byte |
| ta2 | input | 8 | Target address, high byte |
| es | input | 8 | Ending-offset/status byte; bit 5 = partial-write flag |
| copy_prot | input | 8 | Copy-lock byte |
| page_prot | input | NPAGES*8 | Per-page protection bytes |
| spad | input | ROW_BYTES*8 | Scratchpad contents, byte i at bits 8i+7:8i |
| aa_set | output | 1 | One-cycle pulse: copy accepted |
| busy | output | 1 | Programming interval in progress |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | MEM_AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_raddr | output | MEM_AW | Memory read address (one-cycle read latency) |
| mem_rdata | input | 8 | Memory read data |

## Verification
The assertions take several things for granted about the inputs:
- PROG_CYCLES is at least ROW_BYTES+2, so every write falls inside the `busy` window.
- The memory answers a read address one cycle later.
- The scratchpad and address inputs hold still while a copy is programming.
- Read requests are at least two cycles apart, so a new byte has been fetched before each one.

The stimulus meets these conditions. It changes `spad`, the address bytes and the protection bytes only before a command. It spaces every read request by an idle cycle, and every run uses PROG_CYCLES of 40. Random targets cover aligned, unaligned, register-row and out-of-range addresses, together with random lock bytes, partial-write flags and corrupted echoes.

// File: rtl/cac_pkg.sv
package cac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AUTH,
    ST_PROG,
    ST_STREAM,
    ST_RADDR,
    ST_READ,
    ST_HALT
  } cac_state_e;

  localparam logic [7:0] CMD_COPY  = 8'h55;
  localparam logic [7:0] CMD_READ  = 8'hF0;
  localparam logic [7:0] LOCK_WP   = 8'h55;
  localparam logic [7:0] LOCK_EP   = 8'hAA;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] ALT_BYTE  = 8'hAA;
  localparam int         PF_BIT    = 5;

endpackage

// File: rtl/cac_auth.sv
module cac_auth #(
  parameter int NPAGES    = 4,
  parameter int PAGE_ROWS = 4,
  parameter int ROW_BYTES = 8
) (
  input  logic [7:0]          ta1,
  input  logic [7:0]          ta2,
  input  logic [7:0]          es,
  input  logic [7:0]          copy_prot,
  input  logic [NPAGES*8-1:0] page_prot,
  input  logic [1:0]          byte_idx,
  input  logic [7:0]          rx_byte,
  output logic                byte_ok,
  output logic                permit
);
  import cac_pkg::*;

  localparam int ROW_SH  = $clog2(ROW_BYTES);
  localparam int REG_ROW = NPAGES * PAGE_ROWS;

  logic [15:0]       addr;
  logic [15:0]       row;
  logic [7:0]        expect_byte;
  logic [NPAGES-1:0] page_wp;
  logic              aligned, in_range, reg_row, wp_hit, lock_on;

  assign addr = {ta2, ta1};
  assign row  = addr >> ROW_SH;

  genvar g;
  generate
    for (g = 0; g < NPAGES; g++) begin : g_page
      assign page_wp[g] = (page_prot[8*g +: 8] == LOCK_WP);
    end
  endgenerate

  always_comb begin
    wp_hit = 1'b0;
    for (int p = 0; p < NPAGES; p++) begin
      if (row >= 16'(p * PAGE_ROWS) && row < 16'((p + 1) * PAGE_ROWS))
        wp_hit = wp_hit | page_wp[p];
    end
  end

  always_comb begin
    case (byte_idx)
      2'd0:    expect_byte = ta1;
      2'd1:    expect_byte = ta2;
      default: expect_byte = es;
    endcase
  end

  assign byte_ok  = (rx_byte == expect_byte);
  assign aligned  = (addr[ROW_SH-1:0] == '0);
  assign in_range = (row <= 16'(REG_ROW));
  assign reg_row  = (row == 16'(REG_ROW));
  assign lock_on  = (copy_prot == LOCK_WP) || (copy_prot == LOCK_EP);
  assign permit   = aligned && in_range && !es[PF_BIT] &&
                    !(lock_on && (reg_row || wp_hit));

endmodule

// File: rtl/cac_prog_timer.sv
module cac_prog_timer #(
  parameter int CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign last = busy && (cnt == '0);

endmodule

// File: rtl/cac_row_writer.sv
module cac_row_writer #(
  parameter int ROW_BYTES = 8,
  parameter int MEM_AW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [MEM_AW-1:0]      base,
  input  logic [ROW_BYTES*8-1:0] spad,
  output logic                   we,
  output logic [MEM_AW-1:0]      waddr,
  output logic [7:0]             wdata
);
  localparam int IW = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;

  logic              active;
  logic [IW-1:0]     widx;
  logic [MEM_AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      widx   <= '0;
      base_q <= '0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else begin
      we <= 1'b0;
      if (start) begin
        active <= 1'b1;
        widx   <= '0;
        base_q <= base;
      end else if (active) begin
        we    <= 1'b1;
        waddr <= base_q + MEM_AW'(widx);
        wdata <= spad[int'(widx)*8 +: 8];
        widx  <= widx + 1'b1;
        if (widx == IW'(ROW_BYTES - 1)) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cac_commit.sv
module cac_commit #(
  parameter int NPAGES      = 4,
  parameter int PAGE_ROWS   = 4,
  parameter int ROW_BYTES   = 8,
  parameter int PROG_CYCLES = 2500000,
  localparam int MEM_AW     = $clog2((NPAGES * PAGE_ROWS + 2) * ROW_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_reset,
  input  logic                   cmd_valid,
  input  logic [7:0]             cmd_code,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  input  logic                   tx_req,
  output logic                   tx_valid,
  output logic [7:0]             tx_byte,
  input  logic [7:0]             ta1,
  input  logic [7:0]             ta2,
  input  logic [7:0]             es,
  input  logic [7:0]             copy_prot,
  input  logic [NPAGES*8-1:0]    page_prot,
  input  logic [ROW_BYTES*8-1:0] spad,
  output logic                   aa_set,
  output logic                   busy,
  output logic                   mem_we,
  output logic [MEM_AW-1:0]      mem_waddr,
  output logic [7:0]             mem_wdata,
  output logic [MEM_AW-1:0]      mem_raddr,
  input  logic [7:0]             mem_rdata
);
  import cac_pkg::*;

  localparam int          LAST_ADDR = (NPAGES * PAGE_ROWS + 2) * ROW_BYTES - 1;
  localparam logic [15:0] LAST_A16  = 16'(LAST_ADDR);

  cac_state_e  state;
  logic [1:0]  bidx;
  logic        match_q;
  logic [15:0] rd_addr;
  logic        halt_after;
  logic        byte_ok, permit, go, prog_last, rd_in_range;
  logic [15:0] tgt_addr;

  assign tgt_addr    = {ta2, ta1};
  assign rd_in_range = (rd_addr <= LAST_A16);
  assign mem_raddr   = rd_addr[MEM_AW-1:0];

  cac_auth #(
    .NPAGES(NPAGES), .PAGE_ROWS(PAGE_ROWS), .ROW_BYTES(ROW_BYTES)
  ) u_auth (
    .ta1(ta1), .ta2(ta2), .es(es), .copy_prot(copy_prot),
    .page_prot(page_prot), .byte_idx(bidx), .rx_byte(rx_byte),
    .byte_ok(byte_ok), .permit(permit)
  );

  assign go = (state == ST_AUTH) && rx_valid && (bidx == 2'd2) &&
              match_q && byte_ok && permit;

  cac_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(go), .busy(busy), .last(prog_last)
  );

  cac_row_writer #(.ROW_BYTES(ROW_BYTES), .MEM_AW(MEM_AW)) u_writer (
    .clk(clk), .rst(rst), .start(go), .base(tgt_addr[MEM_AW-1:0]),
    .spad(spad), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bidx       <= '0;
      match_q    <= 1'b0;
      rd_addr    <= '0;
      halt_after <= 1'b0;
      aa_set     <= 1'b0;
      tx_valid   <= 1'b0;
      tx_byte    <= FILL_BYTE;
    end else begin
      aa_set   <= 1'b0;
      tx_valid <= 1'b0;
      if (tx_req) begin
        tx_valid <= 1'b1;
        if (state == ST_STREAM)
          tx_byte <= ALT_BYTE;
        else if (state == ST_READ && rd_in_range)
          tx_byte <= mem_rdata;
        else
          tx_byte <= FILL_BYTE;
        if (state == ST_READ && rd_in_range)
          rd_addr <= rd_addr + 16'd1;
      end

      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            bidx    <= '0;
            match_q <= 1'b1;
            if (cmd_code == CMD_COPY)      state <= ST_AUTH;
            else if (cmd_code == CMD_READ) state <= ST_RADDR;
            else                           state <= ST_HALT;
          end
        end
        ST_AUTH: begin
          if (rx_valid) begin
            match_q <= match_q & byte_ok;
            bidx    <= bidx + 2'd1;
            if (bidx == 2'd2) begin
              if (go) begin
                state      <= ST_PROG;
                aa_set     <= 1'b1;
                halt_after <= 1'b0;
              end else begin
                state <= ST_HALT;
              end
            end
          end
        end
        ST_RADDR: begin
          if (rx_valid) begin
            if (bidx == 2'd0) begin
              rd_addr[7:0] <= rx_byte;
              bidx         <= 2'd1;
            end else begin
              rd_addr[15:8] <= rx_byte;
              state         <= ST_READ;
            end
          end
        end
        ST_PROG: begin
          if (bus_reset) halt_after <= 1'b1;
          if (prog_last)
            state <= (halt_after || bus_reset) ? ST_IDLE : ST_STREAM;
        end
        default: ;
      endcase

      if (bus_reset && state != ST_PROG) state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/cac_commit_chk.sv
module cac_commit_chk #(
  parameter int NPAGES      = 4,
  parameter int PAGE_ROWS   = 4,
  parameter int ROW_BYTES   = 8,
  parameter int PROG_CYCLES = 2500000,
  localparam int MEM_AW     = $clog2((NPAGES * PAGE_ROWS + 2) * ROW_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              aa_set,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_waddr,
  input logic              tx_req,
  input logic              tx_valid
);
  localparam int TOP_WADDR = (NPAGES * PAGE_ROWS + 1) * ROW_BYTES - 1;

  int busy_len;
  int wr_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      busy_len <= 0;
      wr_len   <= 0;
    end else begin
      busy_len <= busy_len + 1;
      wr_len   <= wr_len + (mem_we ? 1 : 0);
    end
  end

  // R5
  aa_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    aa_set |-> busy);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> aa_set);

  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R2
  waddr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_waddr) <= TOP_WADDR));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  // R6
  write_count_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (wr_len == ROW_BYTES));

  // R10
  tx_answer_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> tx_valid);

  // R10
  tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

endmodule

bind cac_commit cac_commit_chk #(
  .NPAGES(NPAGES), .PAGE_ROWS(PAGE_ROWS),
  .ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (.*);

// File: tb/cac_commit_test.sv
module cac_commit_test;
  localparam int PROG  = 40;
  localparam int MSIZE = 144;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_req = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [7:0]  ta1 = '0, ta2 = '0, es = '0, copy_prot = '0;
  logic [31:0] page_prot = '0;
  logic [63:0] spad = '0;
  logic        aa_set, busy, mem_we;
  logic [7:0]  mem_waddr, mem_wdata, mem_raddr;
  logic [7:0]  mem_rdata;

  logic [7:0] mem     [0:MSIZE-1];
  logic [7:0] exp_mem [0:MSIZE-1];
  int checks = 0, errors = 0;
  int aa_cnt = 0, we_cnt = 0, busy_cyc = 0;
  logic [7:0] wl_addr [0:15];
  logic [7:0] wl_data [0:15];
  int wptr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cac_commit #(.PROG_CYCLES(PROG)) uut (.*);

  always @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    mem_rdata <= (int'(mem_raddr) < MSIZE) ? mem[mem_raddr] : 8'h00;
    if (!rst) begin
      if (aa_set) aa_cnt <= aa_cnt + 1;
      if (busy) busy_cyc <= busy_cyc + 1;
      if (mem_we) begin
        we_cnt <= we_cnt + 1;
        if (wptr < 16) begin
          wl_addr[wptr] = mem_waddr;
          wl_data[wptr] = mem_wdata;
        end
        wptr = wptr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit permit_f(input [7:0] t1, t2, e, cp, input [31:0] pp);
    logic [15:0] a;
    logic [7:0]  pb;
    bit lock;
    a    = {t2, t1};
    lock = (cp == 8'h55) || (cp == 8'hAA);
    pb   = pp[8*a[6:5] +: 8];
    if (a[2:0] != 3'b000) return 0;
    if (a > 16'h0080) return 0;
    if (e[5]) return 0;
    if (lock && (a == 16'h0080 || pb == 8'h55)) return 0;
    return 1;
  endfunction

  task automatic pulse_reset();
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
  endtask

  task automatic send_cmd(input [7:0] c);
    @(negedge clk) begin cmd_valid = 1'b1; cmd_code = c; end
    @(negedge clk) cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, output logic v);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
    b = tx_byte;
    v = tx_valid;
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_copy(input [7:0] t1, t2, e, cp, input [31:0] pp,
                         input [63:0] sp, input int corrupt);
    logic [7:0] p [0:2];
    logic [7:0] b;
    logic v;
    int a0, w0, b0, base;
    bit ok;
    ta1 = t1; ta2 = t2; es = e; copy_prot = cp; page_prot = pp; spad = sp;
    pulse_reset();
    p[0] = t1; p[1] = t2; p[2] = e;
    if (corrupt > 0) p[corrupt-1] = p[corrupt-1] ^ 8'h10;
    ok = (corrupt == 0) && permit_f(t1, t2, e, cp, pp);
    a0 = aa_cnt; w0 = we_cnt; b0 = busy_cyc; wptr = 0;
    send_cmd(8'h55);
    for (int i = 0; i < 3; i++) send_byte(p[i]);
    wait_cyc(PROG + 12);
    base = int'({t2, t1});
    // R1 R2 R3 R4 R9: decision seen through aa_set and write count
    chk((aa_cnt - a0) == (ok ? 1 : 0), "R5 aa_set pulses", aa_cnt - a0, ok ? 1 : 0);
    chk((we_cnt - w0) == (ok ? 8 : 0), ok ? "R6 write count" : "R9 no writes",
        we_cnt - w0, ok ? 8 : 0);
    chk((busy_cyc - b0) == (ok ? PROG : 0), "R7 busy length", busy_cyc - b0, ok ? PROG : 0);
    if (ok) begin
      for (int i = 0; i < 8; i++) begin
        exp_mem[base+i] = sp[8*i +: 8];
        chk(wl_addr[i] == 8'(base + i) && wl_data[i] == sp[8*i +: 8],
            "R6 write order/data", int'(wl_addr[i]), base + i);
        chk(mem[base+i] == exp_mem[base+i], "R6 row content",
            int'(mem[base+i]), int'(exp_mem[base+i]));
      end
    end
    get_byte(b, v);
    chk(v && b == (ok ? 8'hAA : 8'hFF), ok ? "R8 alternating" : "R1 silent after block",
        int'(b), ok ? 'hAA : 'hFF);
    get_byte(b, v);
    chk(v && b == (ok ? 8'hAA : 8'hFF), "R8 stream continues", int'(b), ok ? 'hAA : 'hFF);
    pulse_reset();
    get_byte(b, v);
    chk(v && b == 8'hFF, "R8 stream ends on bus reset", int'(b), 'hFF);
  endtask

  task automatic do_read(input [15:0] start, input int n);
    logic [7:0] b, e;
    logic v;
    int a, a0, w0;
    pulse_reset();
    a0 = aa_cnt; w0 = we_cnt;
    send_cmd(8'hF0);
    send_byte(start[7:0]);
    send_byte(start[15:8]);
    a = int'(start);
    for (int i = 0; i < n; i++) begin
      get_byte(b, v);
      e = (a <= 'h8F) ? exp_mem[a] : 8'hFF;
      chk(v && b == e, "R10 read data", int'(b), int'(e));
      a++;
    end
    chk(aa_cnt == a0 && we_cnt == w0, "R11 read has no side effects",
        (aa_cnt - a0) + (we_cnt - w0), 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    for (int i = 0; i < MSIZE; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    wait_cyc(4);
    @(negedge clk) rst = 1'b0;
    // R13
    chk(!busy && !aa_set && !mem_we && !tx_valid, "R13 reset state",
        {busy, aa_set, mem_we, tx_valid}, 0);

    // R4 directed: refresh of a 55h page is allowed without the copy lock
    do_copy(8'h20, 8'h00, 8'h07, 8'h00, 32'h0000_5500, 64'h0123_4567_89AB_CDEF, 0);
    // R4 lock + 55h page blocks
    do_copy(8'h20, 8'h00, 8'h07, 8'h55, 32'h0000_5500, 64'h1111_2222_3333_4444, 0);
    // R4 lock blocks register row
    do_copy(8'h80, 8'h00, 8'h07, 8'hAA, 32'h0, 64'h5555_6666_7777_8888, 0);
    // R4 lock with AAh page does not block
    do_copy(8'h48, 8'h00, 8'h07, 8'h55, 32'h00AA_0000, 64'hDEAD_BEEF_CAFE_F00D, 0);
    // R2 unaligned, R3 PF, R1 bad third byte
    do_copy(8'h09, 8'h00, 8'h07, 8'h00, 32'h0, 64'h0, 0);
    do_copy(8'h10, 8'h00, 8'h27, 8'h00, 32'h0, 64'h0, 0);
    do_copy(8'h10, 8'h00, 8'h07, 8'h00, 32'h0, 64'h0, 3);

    // R12 bus reset during programming
    begin
      logic [7:0] b; logic v; int b0, w0;
      ta1 = 8'h60; ta2 = 8'h00; es = 8'h07; copy_prot = 8'h00; page_prot = '0;
      spad = 64'hA5A5_5A5A_0F0F_F0F0;
      pulse_reset();
      b0 = busy_cyc; w0 = we_cnt;
      send_cmd(8'h55);
      send_byte(8'h60); send_byte(8'h00); send_byte(8'h07);
      wait_cyc(5);
      pulse_reset();
      chk(busy == 1'b1, "R12 busy held through bus reset", busy, 1);
      wait_cyc(PROG + 5);
      for (int i = 0; i < 8; i++) exp_mem['h60+i] = spad[8*i +: 8];
      chk(busy_cyc - b0 == PROG && we_cnt - w0 == 8, "R12 full programming",
          busy_cyc - b0, PROG);
      get_byte(b, v);
      chk(v && b == 8'hFF, "R12 idle after programming", int'(b), 'hFF);
      send_cmd(8'hF0); send_byte(8'h60); send_byte(8'h00);
      get_byte(b, v);
      chk(v && b == exp_mem['h60], "R12 new command accepted", int'(b), int'(exp_mem['h60]));
    end

    // R10 reads across the end of memory
    do_read(16'h008D, 5);
    do_read(16'h0000, 4);
    do_read(16'h0120, 2);

    // random copies and reads
    for (int n = 0; n < 40; n++) begin
      logic [7:0] t1, t2, e, cp;
      logic [31:0] pp;
      int r, cor;
      r = int'($urandom % 8);
      if (r < 5)       t1 = 8'(($urandom % 16) * 8);
      else if (r == 5) t1 = 8'h80;
      else if (r == 6) t1 = 8'(($urandom % 136) | 1);
      else             t1 = 8'(8'h88 + ($urandom % 4) * 8);
      t2 = ($urandom % 10 == 0) ? 8'h01 : 8'h00;
      e  = {2'b00, ($urandom % 4 == 0) ? 1'b1 : 1'b0, 2'b00, 3'b111};
      case ($urandom % 4)
        0: cp = 8'h55; 1: cp = 8'hAA; 2: cp = 8'h00; default: cp = 8'($urandom);
      endcase
      for (int p = 0; p < 4; p++)
        case ($urandom % 3)
          0: pp[8*p +: 8] = 8'h55; 1: pp[8*p +: 8] = 8'hAA; default: pp[8*p +: 8] = 8'h00;
        endcase
      cor = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 0;
      do_copy(t1, t2, e, cp, pp, {$urandom, $urandom}, cor);
      if (n % 8 == 0) do_read(16'($urandom % 150), 3);
    end

    // unknown command stays silent
    begin
      logic [7:0] b; logic v;
      pulse_reset();
      send_cmd(8'h3C);
      get_byte(b, v);
      chk(v && b == 8'hFF, "R1 unknown command silent", int'(b), 'hFF);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule